// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Character Transmitter

This block turns one parallel character at a time into a framed serial bit stream on a single output line. Each frame is a space-level start bit, then the data bits least-significant first, then an optional parity bit, then a mark-level stop period. Software-visible framing choices arrive as plain configuration inputs. The character length can be 5, 6, 7 or 8 bits. Parity can be off, even or odd. The stop period can be one, one and a half or two bit times. The usual setting is 8 data bits, no parity and one stop bit, which is ten bit times on the line.

Characters are offered on a valid/ready handshake. The block accepts one only when it is idle, and it samples the character and every configuration field at that moment. Bit timing comes from an external enable pulse running at sixteen times the bit rate, so every bit lasts sixteen pulses and a one-and-a-half stop period lasts twenty-four. Between characters the line rests at mark for as long as no character is offered, and consecutive equal bits produce no transition on the line.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever no character is in flight, `tx_line` is 1 (mark) and `in_ready` is 1, however long the idle gap lasts.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0, and it stays 0 until the final tick of the stop period. `in_valid` held high while `in_ready` is 0 does not start or disturb a frame.
- R3: The start bit is 0. It appears on `tx_line` in the cycle after acceptance and lasts 16 ticks.
- R4: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent from `in_data[0]` upward. Bits of `in_data` above the selected length are ignored.
- R5: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` set to 0 the number of ones across the data bits in use and the parity bit is even; with `cfg_par_odd` set to 1 it is odd. When `cfg_par_en` is 0 no parity bit is sent.
- R6: The stop period is 1 (mark). `cfg_stop` 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 gives 32 ticks. `in_ready` returns to 1 in the cycle after the last stop tick.
- R7: Every non-stop bit lasts exactly 16 ticks. Only ticks that arrive while a frame is in flight count, and a tick in the accepting cycle does not count. The frame's length in ticks does not depend on how many clocks separate the ticks.
- R8: Data and all configuration fields are captured at acceptance. Changing them during the frame has no effect on that frame.
- R9: `tx_line` changes only at a clock edge that carries a tick, or at the edge where a character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | One-cycle enable at sixteen times the bit rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | Idle, a character can be accepted |
| in_data | input | DATA_W | Character, LSB sent first |
| cfg_len | input | 2 | Data length code (0..3 maps to 5..8 bits) |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_stop | input | 2 | Stop length code (0: 1, 1: 1.5, 2/3: 2 bit times) |
| tx_line | output | 1 | Serial output, idles at 1 |

## Verification
On every cycle, the checker confirms these properties: the line is at mark whenever the block reports ready; acceptance drops ready and the line together; nothing moves without a tick during a frame; ready stays up while nothing is offered; the bit before ready returns is mark; and each frame's tick count lies between the shortest and the longest legal frame. The checker cannot see whether the right bit sits in each sixteen-tick slot. The bench's scoreboard shows this by predicting the full bit sequence from the captured character and settings and checking the line at every clock against the elapsed tick count. The same scenarios are the only place to show several other behaviours: the exact stop-period lengths per code, parity sense, masking of unused data bits, and immunity to settings changed mid-frame.

// File: rtl/serial_tx_pkg.sv
// Shared definitions for the serial character transmitter.
// Assumes the minimum character length is 5 bits and a 2-bit length code.
package serial_tx_pkg;

    localparam int MIN_CHAR_BITS = 5;

    // Frame phases in transmission order.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } tx_phase_e;

    // Stop length codes.
    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;

    // Number of ticks in the stop period for a given code and oversampling rate.
    function automatic int stop_ticks(input logic [1:0] code, input int os);
        if (code == STOP_ONE)           return os;
        else if (code == STOP_ONE_HALF) return os + os / 2;
        else                            return 2 * os;
    endfunction

endpackage

// File: rtl/stx_parity_gen.sv
// Parity generator: computes the parity bit over only the data bits selected
// by the length code. Assumes DATA_W >= MIN_CHAR_BITS + 3. Purely combinational.
module stx_parity_gen
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              odd,
    output logic              par_bit
);
    localparam int LW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] mask;
    logic [LW-1:0]     nbits;

    assign nbits = LW'(MIN_CHAR_BITS) + LW'(len_code);

    // One mask bit per data position, set when the position is in use.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (LW'(g) < nbits);
    end

    // Even parity is the XOR of the used bits; odd parity inverts it.
    assign par_bit = (^(data & mask)) ^ odd;

endmodule

// File: rtl/stx_bit_timer.sv
// Bit timer: counts oversampling ticks within the current bit period and
// flags the tick that ends it. Assumes limit is stable during a period and
// clear is held while idle.
module stx_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt;

    assign bit_end = tick && !clear && (cnt == limit);

    // Advances on each tick and wraps at the end of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/stx_frame_ctrl.sv
// Frame controller: accepts a character when idle, latches data and settings,
// and steps through start, data, parity and stop phases on bit_end pulses.
// Drives the registered line output. Assumes bit_end comes from a timer that
// is cleared while idle.
module stx_frame_ctrl
    import serial_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_stop,
    input  logic              par_in,
    input  logic              bit_end,
    output logic              in_ready,
    output logic              tx_line,
    output logic              timer_clear,
    output logic [CNT_W-1:0]  tick_limit
);
    localparam int LEFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] BIT_LIMIT = CNT_W'(OVERSAMPLE - 1);

    tx_phase_e         phase;
    logic [DATA_W-1:0] shreg;
    logic [LEFT_W-1:0] bits_left;
    logic              par_en_q;
    logic              par_q;
    logic [1:0]        stop_q;
    logic              line_q;
    logic              accept;

    assign in_ready    = (phase == PH_IDLE);
    assign accept      = in_valid && in_ready;
    assign tx_line     = line_q;
    assign timer_clear = (phase == PH_IDLE);

    // Selects the length of the current bit period in ticks, minus one.
    always_comb begin
        if (phase == PH_STOP) tick_limit = CNT_W'(stop_ticks(stop_q, OVERSAMPLE) - 1);
        else                  tick_limit = BIT_LIMIT;
    end

    // Phase sequencing, shifting and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            par_en_q  <= 1'b0;
            par_q     <= 1'b0;
            stop_q    <= STOP_ONE;
            line_q    <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase     <= PH_START;
                        shreg     <= in_data;
                        bits_left <= LEFT_W'(MIN_CHAR_BITS - 1) + LEFT_W'(cfg_len);
                        par_en_q  <= cfg_par_en;
                        par_q     <= par_in;
                        stop_q    <= cfg_stop;
                        line_q    <= 1'b0;
                    end
                end
                PH_START: begin
                    if (bit_end) begin
                        phase  <= PH_DATA;
                        line_q <= shreg[0];
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        if (bits_left == '0) begin
                            phase  <= par_en_q ? PH_PARITY : PH_STOP;
                            line_q <= par_en_q ? par_q : 1'b1;
                        end else begin
                            shreg     <= shreg >> 1;
                            line_q    <= shreg[1];
                            bits_left <= bits_left - LEFT_W'(1);
                        end
                    end
                end
                PH_PARITY: begin
                    if (bit_end) begin
                        phase  <= PH_STOP;
                        line_q <= 1'b1;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        phase <= PH_IDLE;
                    end
                end
                default: begin
                    phase  <= PH_IDLE;
                    line_q <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_char_tx.sv
// Top of the asynchronous character transmitter. Connects the parity
// generator, the tick-driven bit timer and the frame controller.
// Assumes tick_16x is a one-cycle pulse at OVERSAMPLE times the bit rate.
module serial_char_tx
    import serial_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    output logic              tx_line
);
    localparam int CNT_W = $clog2(2 * OVERSAMPLE);

    logic             par_bit;
    logic             bit_end;
    logic             timer_clear;
    logic [CNT_W-1:0] tick_limit;

    stx_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data     (in_data),
        .len_code (cfg_len),
        .odd      (cfg_par_odd),
        .par_bit  (par_bit)
    );

    stx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .tick    (tick_16x),
        .limit   (tick_limit),
        .bit_end (bit_end)
    );

    stx_frame_ctrl #(
        .DATA_W     (DATA_W),
        .OVERSAMPLE (OVERSAMPLE),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_stop    (cfg_stop),
        .par_in      (par_bit),
        .bit_end     (bit_end),
        .in_ready    (in_ready),
        .tx_line     (tx_line),
        .timer_clear (timer_clear),
        .tick_limit  (tick_limit)
    );

endmodule

// File: rtl/serial_char_tx_chk.sv
// Property checker for the transmitter, attached through bind. Observes ports
// only; keeps its own tick counter per frame to bound the frame length.
module serial_char_tx_chk
    import serial_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick_16x,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line
);
    localparam logic [15:0] MIN_T = 16'(OVERSAMPLE * (MIN_CHAR_BITS + 2));
    localparam logic [15:0] MAX_T = 16'(OVERSAMPLE * (DATA_W + 4));

    logic [15:0] tick_cnt;

    // Counts ticks that fall inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || (in_valid && in_ready)) tick_cnt <= '0;
        else if (!in_ready && tick_16x)       tick_cnt <= tick_cnt + 16'd1;
    end

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);

    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !tx_line));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !tick_16x) |=> ($stable(tx_line) && !in_ready));

    // R6
    stop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(tx_line));

    // R7
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (tick_cnt >= MIN_T && tick_cnt <= MAX_T));

endmodule

bind serial_char_tx serial_char_tx_chk #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_16x (tick_16x),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line)
);

// File: tb/serial_char_tx_bench.sv
`timescale 1ns/1ps
module serial_char_tx_bench;

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] len;
        logic       pe;
        logic       po;
        logic [1:0] st;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       tx_line;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    tick_div = 3;
    int    tdiv_cnt = 0;
    int    tick_seen = 0;
    bit    in_frame = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    serial_char_tx u_serial_char_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_16x    (tick_16x),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop    (cfg_stop),
        .tx_line     (tx_line)
    );

    // Tick source and tick counter.
    always @(posedge clk) begin
        if (tick_16x) tick_seen <= tick_seen + 1;
        if (tick_div <= 1) begin
            tick_16x <= 1'b1;
        end else if (tdiv_cnt >= tick_div - 1) begin
            tick_16x <= 1'b1;
            tdiv_cnt <= 0;
        end else begin
            tick_16x <= 1'b0;
            tdiv_cnt <= tdiv_cnt + 1;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic int nbits_of(input item_t it);
        return 5 + int'(it.len);
    endfunction

    function automatic int stop_of(input item_t it);
        if (it.st == 2'd0) return 16;
        if (it.st == 2'd1) return 24;
        return 32;
    endfunction

    function automatic int total_of(input item_t it);
        return 16 * (1 + nbits_of(it) + int'(it.pe)) + stop_of(it);
    endfunction

    function automatic logic exp_bit(input item_t it, input int idx);
        int n;
        logic p;
        n = nbits_of(it);
        if (idx == 0) return 1'b0;
        if (idx <= n) return it.d[idx-1];
        if (it.pe && idx == n + 1) begin
            p = it.po;
            for (int i = 0; i < n; i++) p = p ^ it.d[i];
            return p;
        end
        return 1'b1;
    endfunction

    function automatic string tag_of(input item_t it, input int idx);
        int n;
        n = nbits_of(it);
        if (idx == 0) return "R3 R9 start bit";
        if (idx <= n) return "R4 R8 R9 data bit";
        if (it.pe && idx == n + 1) return "R5 parity bit";
        return "R6 stop level";
    endfunction

    // Scoreboard monitor: checks the line against the predicted frame each cycle.
    initial begin
        item_t cur;
        int    base;
        int    k;
        cur  = '0;
        base = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!in_frame) begin
                    if (!in_ready) begin
                        if (q.size() == 0) begin
                            chk("R2 unexpected frame start", 32'd1, 32'd0);
                        end else begin
                            cur      = q.pop_front();
                            base     = tick_seen;
                            in_frame = 1'b1;
                        end
                    end else begin
                        chk("R1 idle line mark", 32'(tx_line), 32'd1);
                    end
                end
                if (in_frame) begin
                    k = tick_seen - base;
                    if (k < total_of(cur)) begin
                        chk("R2 ready low in frame", 32'(in_ready), 32'd0);
                        chk(tag_of(cur, k / 16), 32'(tx_line), 32'(exp_bit(cur, k / 16)));
                    end else begin
                        chk("R6 R7 ready after stop", 32'(in_ready), 32'd1);
                        chk("R7 frame length ticks", 32'(k), 32'(total_of(cur)));
                        in_frame = 1'b0;
                    end
                end
            end
        end
    end

    // Driver: offers one character, waits for acceptance, records it.
    task automatic send(input logic [7:0] d, input logic [1:0] len, input logic pe,
                        input logic po, input logic [1:0] st);
        item_t it;
        in_valid    = 1'b1;
        in_data     = d;
        cfg_len     = len;
        cfg_par_en  = pe;
        cfg_par_odd = po;
        cfg_stop    = st;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        it.d   = d;
        it.len = len;
        it.pe  = pe;
        it.po  = po;
        it.st  = st;
        q.push_back(it);
        in_valid = 1'b0;
        // R8: scramble every input after acceptance
        in_data     = ~d;
        cfg_len     = ~len;
        cfg_par_en  = ~pe;
        cfg_par_odd = ~po;
        cfg_stop    = st + 2'd1;
    endtask

    task automatic drain();
        while (q.size() != 0 || in_frame || !in_ready) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Watchdog.
    initial begin
        #1200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset line", 32'(tx_line), 32'd1);
        chk("R1 reset ready", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // Default 8 bits, no parity, one stop; back-to-back offers (R2)
        send(8'hA5, 2'd3, 1'b0, 1'b0, 2'd0);
        send(8'h00, 2'd3, 1'b0, 1'b0, 2'd0);
        send(8'hFF, 2'd3, 1'b0, 1'b0, 2'd0);
        drain();

        // Long idle gap (R1)
        repeat (200) @(posedge clk);
        #1;

        // Every length, stop code and parity mode (R4 R5 R6)
        for (int l = 0; l < 4; l++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 3; p++) begin
                    send(8'h3C ^ 8'(l * 37 + s * 11 + p * 89), 2'(l), (p != 0), (p == 2), 2'(s));
                end
            end
        end
        drain();

        // Unused upper bits ignored (R4 R5)
        send(8'hE0, 2'd0, 1'b1, 1'b0, 2'd0);
        send(8'hC1, 2'd1, 1'b1, 1'b1, 2'd1);
        send(8'h80, 2'd2, 1'b1, 1'b0, 2'd0);
        drain();

        // Tick on every clock, including the accepting cycle (R7)
        tick_div = 1;
        send(8'h5A, 2'd3, 1'b1, 1'b1, 2'd1);
        send(8'h13, 2'd0, 1'b0, 1'b0, 2'd2);
        drain();

        // Sparse ticks (R7 R9)
        tick_div = 7;
        send(8'h96, 2'd3, 1'b1, 1'b0, 2'd1);
        send(8'h0F, 2'd2, 1'b0, 1'b0, 2'd0);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule